// File: doc/BRIEF.md
# I2C Register Slave with Update Freeze

This block is the two-wire serial front end of a timekeeping register file. It watches the clock and data lines, which it samples with the system clock, and detects START, repeated START and STOP. It answers to one fixed 7-bit device address. A write transfer loads an internal word pointer and then stores data bytes at that pointer. A read transfer returns bytes from the pointer, and the pointer advances each time the master acknowledges a byte. The data line is open-drain: the block only ever drives it low, through `sda_oe_o`.

The block also gates the once-per-second copy of live time into the user-visible clock registers. Registers 00h to 07h are clock registers. While a transfer addressed to this slave is in progress and the pointer lies in that range, the copy is held off. A multi-byte read or write of the time therefore works on one consistent snapshot. A request that arrives during the hold is remembered. It is released as a single `upd_o` pulse as soon as a STOP ends the transfer or the pointer moves past 07h.

Registers live outside the block. The pointer is presented on `reg_addr_o`, and the register file returns `reg_rdata_i` combinationally. Writes are single-cycle pulses on `reg_we_o`.

States of the controller:
- IDLE: no transfer.
- ADDR: shifting in the device-address byte.
- AACK: acknowledging the device address.
- PTR: shifting in the word address.
- PACK: acknowledging the word address.
- WDATA: shifting in a data byte.
- WACK: acknowledging a data byte.
- RDATA: shifting out a data byte.
- RACK: sampling the master's acknowledge.
- WAIT: ignoring the bus until the next START or STOP.

Transitions:
- STOP goes to IDLE from any state.
- START or repeated START goes to ADDR from any state.
- After eight bits, ADDR goes to AACK on an address match, otherwise to WAIT.
- At the end of the acknowledge clock, AACK goes to RDATA (R/W=1) or to PTR (R/W=0).
- PTR goes to PACK after eight bits; PACK goes to WDATA at the end of the acknowledge clock.
- WDATA goes to WACK after eight bits; WACK goes back to WDATA at the end of the acknowledge clock.
- RDATA goes to RACK after eight bits.
- At the end of the acknowledge clock, RACK goes to RDATA if the master acknowledged, otherwise to WAIT.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `upd_o`, `freeze_o` and `reg_we_o` are 0, and `reg_addr_o` is 00h.
- R2: The device address is 1101000b. The address byte is 0xD0 for a write and 0xD1 for a read, and the block acknowledges it by driving SDA low in the ninth clock. Any other address gets no acknowledge. The rest of that transfer is ignored: no write, no pointer change, and SDA is never driven.
- R3: In a write transfer, the first byte after the address byte is loaded into the 6-bit pointer (its low six bits) and is acknowledged.
- R4: Each further byte of a write transfer is written with one `reg_we_o` pulse at the current pointer and acknowledged. The pointer increments at the end of that acknowledge clock.
- R5: In a read transfer, bytes come from the register at the pointer, MSB first. When the master acknowledges a byte, the pointer increments and the next byte comes from the new address.
- R6: After the master does not acknowledge a read byte, the block releases SDA and keeps it released until the next START. The pointer does not increment.
- R7: A read transfer not preceded by a pointer write starts at the address left in the pointer by the previous transfer.
- R8: The pointer wraps from 3Fh to 00h in both write and read transfers.
- R9: While a transfer addressed to this slave is open and the pointer is in 00h to 07h, `freeze_o` is 1 and a `tick_i` pulse produces no `upd_o` pulse.
- R10: The freeze ends on STOP or when the pointer leaves 00h to 07h. Any number of ticks seen during the freeze then produce exactly one `upd_o` pulse.
- R11: A `tick_i` pulse while not frozen gives a one-cycle `upd_o` pulse in the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| tick_i | input | 1 | One-cycle update request from the timekeeper |
| upd_o | output | 1 | One-cycle pulse: copy live time into clock registers |
| freeze_o | output | 1 | Clock-register update currently held off |
| reg_addr_o | output | 6 | Register address (the word pointer) |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, combinational |

## Verification
A pointer that is off by one shows up within a single byte time, as a wrong read byte or a write to the neighbouring register. The bench tells the two apart by reading back across the acknowledge and NACK boundaries and across the 3Fh wrap. A controller left in a transmitting or acknowledging state drives SDA in a bit slot where the master expects a released line, so it is seen in the very next clock of the bus. Freeze bookkeeping errors show at `upd_o`. A lost or doubled update is visible in the cycle count of pulses right after STOP or after the pointer moves past 07h. A leaked update is visible one cycle after a tick during the freeze.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_PTR,
        S_PACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK,
        S_WAIT
    } slv_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // lines idle high, so reset to 1 to avoid a false START
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
    import i2c_rs_pkg::*;
#(
    parameter int         PTR_W    = 6,
    parameter logic [6:0] DEV_ADDR = 7'b1101000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output logic              sda_oe_o,
    output logic              active_o,
    output slv_state_e        state_o
);

    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    slv_state_e         state_q, state_n;
    logic [BYTE_W-1:0]  rx_q;
    logic [BYTE_W-1:0]  tx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [PTR_W-1:0]   ptr_q;
    logic               rw_q;
    logic               mack_q;
    logic               oe_q;
    logic               we_q;
    logic [BYTE_W-1:0]  wdata_q;
    logic               active_q;
    logic               byte_done;
    logic               addr_hit;
    logic               tx_done;

    assign byte_done = scl_fall && (cnt_q == CNT_FULL);
    assign tx_done   = scl_fall && (cnt_q == CNT_LAST);
    assign addr_hit  = (rx_q[BYTE_W-1:1] == DEV_ADDR);

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (stop_det) begin
            state_n = S_IDLE;
        end else if (start_det) begin
            state_n = S_ADDR;
        end else begin
            unique case (state_q)
                S_IDLE:  state_n = S_IDLE;
                S_ADDR:  if (byte_done) state_n = addr_hit ? S_AACK : S_WAIT;
                S_AACK:  if (scl_fall)  state_n = rw_q ? S_RDATA : S_PTR;
                S_PTR:   if (byte_done) state_n = S_PACK;
                S_PACK:  if (scl_fall)  state_n = S_WDATA;
                S_WDATA: if (byte_done) state_n = S_WACK;
                S_WACK:  if (scl_fall)  state_n = S_WDATA;
                S_RDATA: if (tx_done)   state_n = S_RACK;
                S_RACK:  if (scl_fall)  state_n = mack_q ? S_RDATA : S_WAIT;
                S_WAIT:  state_n = S_WAIT;
                default: state_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            tx_q     <= '0;
            cnt_q    <= '0;
            ptr_q    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            active_q <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (stop_det) begin
                oe_q     <= 1'b0;
                cnt_q    <= '0;
                active_q <= 1'b0;
            end else if (start_det) begin
                oe_q  <= 1'b0;
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    S_ADDR, S_PTR, S_WDATA: begin
                        if (scl_rise) begin
                            rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (byte_done) begin
                            cnt_q <= '0;
                            if (state_q == S_ADDR) begin
                                if (addr_hit) begin
                                    oe_q     <= 1'b1;
                                    rw_q     <= rx_q[0];
                                    active_q <= 1'b1;
                                end
                            end else if (state_q == S_PTR) begin
                                ptr_q <= rx_q[PTR_W-1:0];
                                oe_q  <= 1'b1;
                            end else begin
                                wdata_q <= rx_q;
                                we_q    <= 1'b1;
                                oe_q    <= 1'b1;
                            end
                        end
                    end
                    S_AACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                tx_q <= rdata;
                                oe_q <= ~rdata[BYTE_W-1];
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    S_PACK: begin
                        if (scl_fall) oe_q <= 1'b0;
                    end
                    S_WACK: begin
                        if (scl_fall) begin
                            oe_q  <= 1'b0;
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                    S_RDATA: begin
                        if (tx_done) begin
                            oe_q  <= 1'b0;
                            cnt_q <= '0;
                        end else if (scl_fall) begin
                            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~tx_q[BYTE_W-2];
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                            if (!sda_s) ptr_q <= ptr_q + 1'b1;
                        end
                        if (scl_fall && mack_q) begin
                            tx_q  <= rdata;
                            oe_q  <= ~rdata[BYTE_W-1];
                            cnt_q <= '0;
                        end
                    end
                    S_IDLE, S_WAIT: oe_q <= 1'b0;
                    default:        oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign ptr_o    = ptr_q;
    assign wdata_o  = wdata_q;
    assign we_o     = we_q;
    assign sda_oe_o = oe_q;
    assign active_o = active_q;
    assign state_o  = state_q;

endmodule

// File: rtl/i2c_rs_freeze.sv
module i2c_rs_freeze #(
    parameter int PTR_W    = 6,
    parameter int CLK_REGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic             freeze_o,
    output logic             upd_o
);

    localparam logic [PTR_W-1:0] CLK_LIM = PTR_W'(CLK_REGS);

    logic pend_q;
    logic upd_q;
    logic frz;

    assign frz = active_i && (ptr_i < CLK_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            upd_q  <= !frz && (tick_i || pend_q);
            pend_q <= frz && (pend_q || tick_i);
        end
    end

    assign freeze_o = frz;
    assign upd_o    = upd_q;

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_rs_pkg::*;
#(
    parameter int         PTR_W    = 6,
    parameter int         CLK_REGS = 8,
    parameter int         SYNC_STG = 2,
    parameter logic [6:0] DEV_ADDR = 7'b1101000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              tick_i,
    output logic              upd_o,
    output logic              freeze_o,
    output logic [PTR_W-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       active;
    logic [PTR_W-1:0] ptr;
    slv_state_e fsm_state;

    i2c_rs_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rs_fsm #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (reg_rdata_i),
        .ptr_o     (ptr),
        .wdata_o   (reg_wdata_o),
        .we_o      (reg_we_o),
        .sda_oe_o  (sda_oe_o),
        .active_o  (active),
        .state_o   (fsm_state)
    );

    i2c_rs_freeze #(.PTR_W(PTR_W), .CLK_REGS(CLK_REGS)) u_frz (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .active_i (active),
        .ptr_i    (ptr),
        .freeze_o (freeze_o),
        .upd_o    (upd_o)
    );

    assign reg_addr_o = ptr;

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
    import i2c_rs_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             upd_o,
    input logic             freeze_o,
    input logic             sda_oe_o,
    input logic             reg_we_o,
    input logic             stop_det,
    input slv_state_e       state,
    input logic [PTR_W-1:0] ptr
);

    // R9
    upd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> !$past(freeze_o));

    // R11
    upd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_o) |=> upd_o);

    // R10
    stop_thaw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !freeze_o);

    // R4
    we_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (state == S_WACK));

    // R6
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE) || (state == S_WAIT)) |-> !sda_oe_o);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && ($past(state) != S_PTR)) |-> (ptr == PTR_W'($past(ptr) + 1'b1)));

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .upd_o    (upd_o),
    .freeze_o (freeze_o),
    .sda_oe_o (sda_oe_o),
    .reg_we_o (reg_we_o),
    .stop_det (stop_det),
    .state    (fsm_state),
    .ptr      (ptr)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       tick = 1'b0;
    logic       sda_oe;
    logic       upd;
    logic       freeze;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       sda_line;
    logic [7:0] mem [64];

    int checks = 0;
    int failures = 0;
    int upd_cnt = 0;
    bit watch = 1'b0;
    bit oe_seen = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_reg_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .tick_i      (tick),
        .upd_o       (upd),
        .freeze_o    (freeze),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_rdata_i (reg_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (upd) upd_cnt <= upd_cnt + 1;
        if (watch && sda_oe) oe_seen <= 1'b1;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic put_byte(logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic pulse_tick;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 sda_oe", sda_oe, 0);
        check("R1 upd", upd, 0);
        check("R1 freeze", freeze, 0);
        check("R1 reg_we", reg_we, 0);
        check("R1 reg_addr", reg_addr, 0);
    endtask

    task automatic t_write;
        logic a;
        bus_start;
        put_byte(8'hD0, a); check("R2 address ack", a, 0);
        put_byte(8'h10, a); check("R3 pointer ack", a, 0);
        check("R3 pointer loaded", reg_addr, 6'h10);
        put_byte(8'h5A, a); check("R4 data ack", a, 0);
        put_byte(8'h6B, a);
        bus_stop;
        check("R4 first write", mem[16], 8'h5A);
        check("R4 second write", mem[17], 8'h6B);
        check("R4 pointer after", reg_addr, 6'h12);
    endtask

    task automatic t_rand_read;
        logic a;
        logic b;
        logic [7:0] v;
        bus_start;
        put_byte(8'hD0, a);
        put_byte(8'h20, a);
        bus_start;
        put_byte(8'hD1, a); check("R2 read address ack", a, 0);
        get_byte(1'b1, v); check("R5 byte 0", v, init_val(32));
        get_byte(1'b1, v); check("R5 byte 1", v, init_val(33));
        get_byte(1'b0, v); check("R5 byte 2", v, init_val(34));
        oe_seen = 1'b0;
        watch = 1'b1;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            check("R6 line released", b, 1);
        end
        watch = 1'b0;
        check("R6 no drive after nack", oe_seen, 0);
        bus_stop;
        check("R6 pointer held on nack", reg_addr, 6'h22);
    endtask

    task automatic t_cur_read;
        logic a;
        logic [7:0] v;
        bus_start;
        put_byte(8'hD1, a);
        get_byte(1'b0, v);
        bus_stop;
        check("R7 current address read", v, init_val(34));
    endtask

    task automatic t_foreign;
        logic a;
        logic [7:0] v;
        oe_seen = 1'b0;
        watch = 1'b1;
        bus_start;
        put_byte(8'hA0, a); check("R2 foreign no ack", a, 1);
        put_byte(8'h30, a);
        put_byte(8'hEE, a);
        bus_stop;
        watch = 1'b0;
        check("R2 foreign never drives", oe_seen, 0);
        check("R2 foreign no write", mem[34], init_val(34));
        bus_start;
        put_byte(8'hD1, a);
        get_byte(1'b0, v);
        bus_stop;
        check("R2 foreign pointer untouched", v, init_val(34));
    endtask

    task automatic t_wrap;
        logic a;
        logic [7:0] v;
        bus_start;
        put_byte(8'hD0, a);
        put_byte(8'h3F, a);
        put_byte(8'h11, a);
        put_byte(8'h22, a);
        bus_stop;
        check("R8 write at 3F", mem[63], 8'h11);
        check("R8 write wrapped to 00", mem[0], 8'h22);
        bus_start;
        put_byte(8'hD0, a);
        put_byte(8'h3F, a);
        bus_start;
        put_byte(8'hD1, a);
        get_byte(1'b1, v); check("R8 read at 3F", v, 8'h11);
        get_byte(1'b0, v); check("R8 read wrapped", v, 8'h22);
        bus_stop;
    endtask

    task automatic t_freeze_stop;
        logic a;
        int c0;
        bus_start;
        put_byte(8'hD0, a);
        put_byte(8'h05, a);
        check("R9 freeze on", freeze, 1);
        c0 = upd_cnt;
        pulse_tick;
        wq(20);
        pulse_tick;
        wq(20);
        check("R9 no update while frozen", upd_cnt, c0);
        bus_stop;
        wq(10);
        check("R10 freeze off after stop", freeze, 0);
        check("R10 one update after stop", upd_cnt, c0 + 1);
    endtask

    task automatic t_freeze_leave;
        logic a;
        logic [7:0] v;
        int c0;
        bus_start;
        put_byte(8'hD0, a);
        put_byte(8'h07, a);
        bus_start;
        put_byte(8'hD1, a);
        c0 = upd_cnt;
        pulse_tick;
        wq(20);
        check("R9 frozen at 07", upd_cnt, c0);
        get_byte(1'b1, v);
        check("R5 read at 07", v, init_val(7));
        check("R10 freeze off past 07", freeze, 0);
        check("R10 update on leaving range", upd_cnt, c0 + 1);
        get_byte(1'b0, v);
        check("R5 read at 08", v, init_val(8));
        bus_stop;
        wq(10);
        check("R10 no extra update", upd_cnt, c0 + 1);
    endtask

    task automatic t_free_tick;
        int c0;
        c0 = upd_cnt;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check("R11 pulse next cycle", upd, 1);
        @(negedge clk);
        check("R11 single cycle", upd, 0);
        check("R11 one pulse", upd_cnt, c0 + 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run;
    end

    initial begin
        wq(5);
        t_reset;
        rst_n = 1'b1;
        wq(5);
        t_write;
        t_rand_read;
        t_cur_read;
        t_foreign;
        t_wrap;
        t_freeze_stop;
        t_freeze_leave;
        t_free_tick;
        wq(5);
        finish_run;
    end

endmodule